// File: doc/BRIEF.md
# Secondary Interrupt Controller with Line Passthrough

This block gathers 32 level-sensitive interrupt sources and folds them into one combined request for a primary interrupt controller. Each source is gated by its own enable bit, and the combined request is high while any enabled source is active. Software can also raise any source itself through a set of software-interrupt bits. These bits are ORed with the hardware inputs to form the effective level of each line.

Lines 21 to 30 can also skip the combined request. When a line's passthrough-enable bit is set, the block drives that line's effective level straight onto the primary controller's line with the same number. Every output is combinational from the inputs and the stored state, so a source change shows on the outputs in the same cycle.

Software uses a word-addressed register bus over a 4 KB window. The word index is byte address bits [11:2]; address bits [1:0] are ignored. Writes take effect on the clock edge. Read data is combinational.

Top module: `sic_top`

## Requirements
- R1: After reset, the enable mask, the software-interrupt bits and the passthrough-enable register are all zero. `irq_combined` is low and `irq_route` is zero for any `irq_in`.
- R2: The effective level of line i is `irq_in[i]` OR software bit i. A read of word 1 returns the effective level vector without masking.
- R3: `irq_combined` is high exactly when (effective level AND mask) is nonzero. A read of word 0 returns that AND.
- R4: A write to word 2 ORs the data into the mask. A write to word 3 clears every mask bit that is 1 in the data. A read of word 2 returns the mask.
- R5: A write to word 4 sets every software bit that is 1 in the data. A write to word 5 clears every software bit that is 1 in the data. Zero bits leave the state unchanged. A read of word 4 returns the software bits.
- R6: A write to word 8 ORs the data, masked with 0x7FE00000, into the passthrough-enable register, so only bits 21 to 30 can ever be set. A read of word 8 returns the register.
- R7: A write to word 9 clears every passthrough-enable bit that is 1 in the data.
- R8: For i in 21..30, `irq_route[i]` equals passthrough-enable bit i AND the effective level of line i, in the same cycle an input changes. All other `irq_route` bits are always 0.
- R9: Reads of words 3, 5, 6, 7, 9 to 15 and of any word at 16 or above return zero. Writes to words 0, 1, 6, 7, 10 to 15 and any word at 16 or above change no state. Address bits [1:0] do not affect decoding.
- R10: State changes only on a clock edge where `bus_sel` and `bus_wr` are both high. `bus_rdata` is zero unless `bus_sel` is high and `bus_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_combined | output | 1 | OR of masked effective levels toward the primary controller |
| irq_route | output | 32 | Per-line passthrough outputs (bits 21..30 active) |

## Verification
The masked combine is driven with sources that are enabled and with sources that are not, and with requests from the hardware pins and from the software bits. This shows whether the block ORs the two request paths and applies the mask, rather than only the one or the other. The passthrough lines are toggled with their enables set and clear. Lines 20 and 31 sit at the edges of the range and are driven along with lines inside it, so a range that is off by one at either end gives a different output. Writes to undecoded words, and reads with nonzero low address bits, separate a full decode from a partial one.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Word indices with a defined meaning (byte address bits [5:2]).
    typedef enum logic [3:0] {
        W_STATUS = 4'd0,
        W_RAW    = 4'd1,
        W_ENSET  = 4'd2,
        W_ENCLR  = 4'd3,
        W_SWSET  = 4'd4,
        W_SWCLR  = 4'd5,
        W_PTSET  = 4'd8,
        W_PTCLR  = 4'd9
    } sic_word_e;

    // One write strobe per state-changing register word.
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic sw_set;
        logic sw_clr;
        logic pt_set;
        logic pt_clr;
    } sic_wr_t;

endpackage

// File: rtl/sic_decode.sv
module sic_decode
    import sic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output sic_wr_t           wr_stb,
    output logic              rd_hit,
    output logic [3:0]        rd_word
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              in_low;
    logic              unused_byte_lane;

    assign word_idx         = addr[ADDR_W-1:2];
    assign unused_byte_lane = ^addr[1:0];
    assign in_low           = ((word_idx >> 4) == '0);
    assign rd_word          = word_idx[3:0];

    always_comb begin
        wr_stb = '0;
        rd_hit = 1'b0;
        if (sel && in_low) begin
            if (wr_en) begin
                case (rd_word)
                    W_ENSET: wr_stb.en_set = 1'b1;
                    W_ENCLR: wr_stb.en_clr = 1'b1;
                    W_SWSET: wr_stb.sw_set = 1'b1;
                    W_SWCLR: wr_stb.sw_clr = 1'b1;
                    W_PTSET: wr_stb.pt_set = 1'b1;
                    W_PTCLR: wr_stb.pt_clr = 1'b1;
                    default: ;
                endcase
            end else begin
                rd_hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sic_regfile.sv
module sic_regfile
    import sic_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PT_LO   = 21,
    parameter int PT_HI   = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sic_wr_t            wr_stb,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] mask_q,
    output logic [N_LINES-1:0] soft_q,
    output logic [N_LINES-1:0] pten_q
);

    logic [N_LINES-1:0] pt_allow;
    logic               any_wr;

    for (genvar i = 0; i < N_LINES; i++) begin : g_allow
        assign pt_allow[i] = (i >= PT_LO) && (i <= PT_HI);
    end

    assign any_wr = wr_stb.en_set | wr_stb.en_clr | wr_stb.sw_set |
                    wr_stb.sw_clr | wr_stb.pt_set | wr_stb.pt_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            soft_q <= '0;
            pten_q <= '0;
        end else begin
            if (wr_stb.en_set) mask_q <= mask_q | wdata;
            if (wr_stb.en_clr) mask_q <= mask_q & ~wdata;
            if (wr_stb.sw_set) soft_q <= soft_q | wdata;
            if (wr_stb.sw_clr) soft_q <= soft_q & ~wdata;
            if (wr_stb.pt_set) pten_q <= pten_q | (wdata & pt_allow);
            if (wr_stb.pt_clr) pten_q <= pten_q & ~wdata;
        end
    end

    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb.en_clr |=> ((mask_q & $past(wdata)) == '0));

    assert_soft_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb.sw_set |=> ((soft_q & $past(wdata)) == $past(wdata)));

    assert_pten_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb.pt_set |=> (((pten_q & $past(wdata) & pt_allow) == ($past(wdata) & pt_allow))
                           && ((pten_q & ~pt_allow) == '0)));

    assert_pten_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb.pt_clr |=> ((pten_q & $past(wdata)) == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> ($stable(mask_q) && $stable(soft_q) && $stable(pten_q)));

endmodule

// File: rtl/sic_route.sv
module sic_route #(
    parameter int N_LINES = 32,
    parameter int PT_LO   = 21,
    parameter int PT_HI   = 30
) (
    input  logic [N_LINES-1:0] level,
    input  logic [N_LINES-1:0] pten,
    output logic [N_LINES-1:0] route
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam bit IN_RANGE = (i >= PT_LO) && (i <= PT_HI);
        assign route[i] = IN_RANGE & pten[i] & level[i];
    end

endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int ADDR_W  = 12,
    parameter int PT_LO   = 21,
    parameter int PT_HI   = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic               irq_combined,
    output logic [N_LINES-1:0] irq_route
);

    sic_wr_t            wr_stb;
    logic               rd_hit;
    logic [3:0]         rd_word;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] soft_q;
    logic [N_LINES-1:0] pten_q;
    logic [N_LINES-1:0] level;
    logic [N_LINES-1:0] status;

    sic_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel     (bus_sel),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wr_stb  (wr_stb),
        .rd_hit  (rd_hit),
        .rd_word (rd_word)
    );

    sic_regfile #(.N_LINES(N_LINES), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wdata  (bus_wdata),
        .mask_q (mask_q),
        .soft_q (soft_q),
        .pten_q (pten_q)
    );

    assign level        = irq_in | soft_q;
    assign status       = level & mask_q;
    assign irq_combined = |status;

    sic_route #(.N_LINES(N_LINES), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_route (
        .level (level),
        .pten  (pten_q),
        .route (irq_route)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            case (rd_word)
                W_STATUS: bus_rdata = status;
                W_RAW:    bus_rdata = level;
                W_ENSET:  bus_rdata = mask_q;
                W_SWSET:  bus_rdata = soft_q;
                W_PTSET:  bus_rdata = pten_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: tb/test_sic_top.sv
`timescale 1ns/1ps
module test_sic_top;

    localparam bit [31:0] PT_BITS = 32'h7FE0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_combined;
    logic [31:0] irq_route;

    int n_chk = 0;
    int n_fail = 0;
    bit live = 1'b0;

    bit [31:0] m_mask = '0, m_soft = '0, m_pten = '0;

    sic_top i_sic_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_combined(irq_combined), .irq_route(irq_route)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] eff();
        return irq_in | m_soft;
    endfunction

    function automatic bit [31:0] model_read(int word);
        case (word)
            0: return eff() & m_mask;
            1: return eff();
            2: return m_mask;
            4: return m_soft;
            8: return m_pten;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(int word, bit [31:0] d);
        case (word)
            2: m_mask = m_mask | d;
            3: m_mask = m_mask & ~d;
            4: m_soft = m_soft | d;
            5: m_soft = m_soft & ~d;
            8: m_pten = m_pten | (d & PT_BITS);
            9: m_pten = m_pten & ~d;
            default: ;
        endcase
    endtask

    task automatic chk_outs(string tag);
        chk({tag, " R3 combined"}, {31'b0, irq_combined}, {31'b0, |(eff() & m_mask)});
        chk({tag, " R8 route"}, irq_route, eff() & m_pten);
    endtask

    // Every-cycle comparison against the reference model.
    always @(negedge clk) if (live) chk_outs("cyc");

    task automatic do_write(int word, bit [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 12'(word << 2); bus_wdata = d;
        @(posedge clk);
        #1;
        model_write(word, d);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(int word, logic [1:0] lo, string req);
        @(negedge clk);
        #1;
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = {word[9:0], lo};
        #1;
        chk(req, bus_rdata, model_read(word));
        bus_sel = 1'b0;
        #1;
        chk("R10 rdata idle", bus_rdata, 32'h0);
    endtask

    task automatic set_in(bit [31:0] v);
        @(posedge clk);
        #2;
        irq_in = v;
        #1;
        chk_outs("same-cycle");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 combined in reset", {31'b0, irq_combined}, 32'h0);
        chk("R1 route in reset", irq_route, 32'h0);
        rst_n = 1'b1;
        live = 1'b1;
        do_read(2, 2'b00, "R1 mask zero");
        do_read(4, 2'b00, "R1 soft zero");
        do_read(8, 2'b00, "R1 pten zero");
        set_in(32'hFFFF_FFFF);
        chk("R1 route with all inputs", irq_route, 32'h0);
        chk("R1 combined with all inputs", {31'b0, irq_combined}, 32'h0);

        // R2/R3: raw and masked status
        set_in(32'h1234_5678);
        do_read(1, 2'b00, "R2 raw level");
        do_read(0, 2'b00, "R3 status masked off");
        do_write(2, 32'h0000_00F0);
        do_read(2, 2'b00, "R4 mask after set");
        set_in(32'h0000_0010);
        chk("R3 enabled source", {31'b0, irq_combined}, 32'h1);
        set_in(32'h0000_0001);
        chk("R3 disabled source", {31'b0, irq_combined}, 32'h0);
        do_write(2, 32'h0000_0100);
        do_write(3, 32'h0000_0010);
        do_read(2, 2'b00, "R4 mask after clear");
        do_read(0, 2'b00, "R3 status");

        // R5: software bits
        do_write(4, 32'h0000_0040);
        chk("R5 soft raises combined", {31'b0, irq_combined}, 32'h1);
        do_write(4, 32'h0000_0000);
        do_read(4, 2'b00, "R5 zero write no effect");
        do_read(1, 2'b00, "R2 raw includes soft");
        do_write(5, 32'h0000_0000);
        do_read(4, 2'b00, "R5 zero clear no effect");
        do_write(5, 32'h0000_0040);
        do_read(4, 2'b00, "R5 soft cleared");
        chk("R5 combined after clear", {31'b0, irq_combined}, 32'h0);

        // R6/R7/R8: passthrough
        do_write(8, 32'hFFFF_FFFF);
        do_read(8, 2'b00, "R6 pten restricted");
        set_in(32'hC060_0000);
        chk("R8 edges and inside", irq_route, 32'h4060_0000);
        set_in(32'h8010_0000);
        chk("R8 bit20 and bit31 never routed", irq_route, 32'h0);
        set_in(32'h7FE0_0000);
        do_write(9, 32'h0020_0000);
        do_read(8, 2'b00, "R7 pten bit21 cleared");
        chk("R7 route drops line21", irq_route, 32'h7FC0_0000);
        set_in(32'h0);
        do_write(4, 32'h0040_0000);
        chk("R8 soft bit routed", irq_route, 32'h0040_0000);
        do_write(5, 32'h0040_0000);

        // R9: undefined words and byte lanes
        do_write(0, 32'hFFFF_FFFF);
        do_write(1, 32'hFFFF_FFFF);
        do_write(6, 32'hFFFF_FFFF);
        do_write(7, 32'hFFFF_FFFF);
        do_write(18, 32'hFFFF_FFFF);
        do_write(1023, 32'hFFFF_FFFF);
        do_read(2, 2'b00, "R9 mask unchanged");
        do_read(4, 2'b00, "R9 soft unchanged");
        do_read(8, 2'b00, "R9 pten unchanged");
        do_read(3, 2'b00, "R9 word3 reads zero");
        do_read(9, 2'b00, "R9 word9 reads zero");
        do_read(16, 2'b00, "R9 word16 reads zero");
        do_read(2, 2'b11, "R9 low addr bits ignored");

        // R10: read strobe does not write
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = 12'(3 << 2); bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        do_read(2, 2'b00, "R10 mask untouched by non-write");

        repeat (2) @(posedge clk);
        live = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule